// File: doc/BRIEF.md
# Redundant-to-Binary Result Adder

This block turns the carry-save output of a word-parallel modular multiplier array into one ordinary binary integer. The array delivers one sum word and one carry word per processing element. Sum word `j` has weight `2^(j*k)`. Carry word `j` is `k+1` bits wide and has weight `2^((j+1)*k)`. Because the carry words are one bit wider than the word pitch, the top bit of each carry word lands on the lowest bit position of the next carry word.

The lowest sum word passes straight to the result. Everything above it is built from three aligned long operands: the upper sum words, the low `k` bits of every carry word, and the isolated top carry bits. One carry-save layer folds these three operands into two, and the pair is registered in the same cycle. A narrow carry-propagate adder of `SLICE_W` bits then walks across the pair, least-significant slice first, with the slice carry held in a register between cycles.

The slice width is chosen near the array's own three-operand critical path, normally between `3k` and `4k`. While the adder walks, the multiplier array is free to run the next independent multiplication. The adder takes a new operation only when it is idle.

Top module: `redundant_result_adder`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is zero.
- R2: The result equals the sum of every `s_j * 2^(j*k)` and every `c_j * 2^((j+1)*k)`. Here `s_j` is `sumWords[j*k +: k]` and `c_j` is `carryWords[j*(k+1) +: k+1]`, so that bit `k` of `c_j` carries weight `2^((j+2)*k)`.
- R3: The low `k` bits of `result` equal `s_0`, whatever the carry words hold.
- R4: A start seen while idle is accepted at that clock edge. `done` then goes high exactly `ceil(k*(n+1)/SLICE_W)` edges later (3 at the defaults) and stays high for one cycle only.
- R5: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high; `busy` is low in that cycle.
- R6: A start raised while `busy` is high is ignored: the result reported is that of the operands accepted first.
- R7: `result` holds its value from one `done` until the next `done`, including while a later operation is in progress.
- R8: All-ones sum and carry words, the largest possible inputs, give the exact sum without any loss of high bits.
- R9: A start raised in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to convert the presented words |
| sumWords | input | NUM_WORDS*WORD_W | Sum words; word j is at bits [j*WORD_W +: WORD_W] |
| carryWords | input | NUM_WORDS*(WORD_W+1) | Carry words; word j is at bits [j*(WORD_W+1) +: WORD_W+1] |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse: the result has just been updated |
| result | output | WORD_W*(NUM_WORDS+2) | Binary sum of the redundant input |

## Verification
The no-overflow assertion relies on the carry words never exceeding `k+1` bits and on the sum words never exceeding `k` bits. Under that input width, the sum always fits in `k*(n+2)` bits, and the final slice never produces a carry. The port widths enforce this bound by construction. The stimulus fills every bit of both buses, from random draws and from all-ones patterns, so the bound is approached but never broken. The control assertions assume that `start` is a plain level sampled at each edge. The bench drives it only between edges, including in the cycle where `done` is high and while the block is busy.

// File: rtl/rra_pkg.sv
package rra_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } rraCtl_t;
endpackage

// File: rtl/rra_ctrl.sv
module rra_ctrl
  import rra_pkg::*;
#(
  parameter int NUM_SLICES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output rraCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SLICES - 1);

  logic             busyReg;
  logic             doneReg;
  logic [CNT_W-1:0] sliceCnt;

  always_comb begin
    ctl.load = !busyReg && start;
    ctl.step = busyReg;
    ctl.last = busyReg && (sliceCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg  <= 1'b0;
      doneReg  <= 1'b0;
      sliceCnt <= '0;
    end else begin
      doneReg <= ctl.last;
      if (!busyReg) begin
        if (start) begin
          busyReg  <= 1'b1;
          sliceCnt <= '0;
        end
      end else if (sliceCnt == LAST_IDX) begin
        busyReg <= 1'b0;
      end else begin
        sliceCnt <= sliceCnt + 1'b1;
      end
    end
  end

  assign busy = busyReg;
  assign done = doneReg;

  // R4: an idle start makes the block busy on the next cycle
  a_r4_start_to_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5: busy is already low in the done cycle
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R5: done only follows a busy cycle
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/rra_datapath.sv
module rra_datapath
  import rra_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int NUM_WORDS  = 8,
  parameter int SLICE_W    = 56,
  parameter int NUM_SLICES = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rraCtl_t                           ctl,
  input  logic [NUM_WORDS*WORD_W-1:0]       sumWords,
  input  logic [NUM_WORDS*(WORD_W+1)-1:0]   carryWords,
  output logic [WORD_W*(NUM_WORDS+2)-1:0]   result
);
  localparam int UP_W  = WORD_W * (NUM_WORDS + 1);
  localparam int PAD_W = NUM_SLICES * SLICE_W;
  localparam int CW    = WORD_W + 1;

  logic [UP_W-1:0]   opSum, opLow, opTop, csaX, csaMaj;
  logic [PAD_W-1:0]  sumReg, carReg, accReg, accNext;
  logic [WORD_W-1:0] lowReg;
  logic              cyReg;
  logic [SLICE_W:0]  sliceAdd;
  logic [UP_W+WORD_W-1:0] outReg;

  // three aligned operands above the lowest word
  always_comb begin
    opSum = '0;
    opSum[(NUM_WORDS-1)*WORD_W-1:0] = sumWords[NUM_WORDS*WORD_W-1:WORD_W];
  end

  for (genvar j = 0; j < NUM_WORDS; j++) begin : g_carry
    assign opLow[j*WORD_W +: WORD_W] = carryWords[j*CW +: WORD_W];
    assign opTop[j*WORD_W +: WORD_W] =
      {{(WORD_W-1){1'b0}}, (j == 0) ? 1'b0 : carryWords[(j-1)*CW + WORD_W]};
  end
  assign opLow[UP_W-1 -: WORD_W] = '0;
  assign opTop[UP_W-1 -: WORD_W] =
    {{(WORD_W-1){1'b0}}, carryWords[(NUM_WORDS-1)*CW + WORD_W]};

  // carry-save layer
  assign csaX   = opSum ^ opLow ^ opTop;
  assign csaMaj = (opSum & opLow) | (opSum & opTop) | (opLow & opTop);

  assign sliceAdd = {1'b0, sumReg[SLICE_W-1:0]} + {1'b0, carReg[SLICE_W-1:0]}
                  + {{SLICE_W{1'b0}}, cyReg};
  assign accNext  = {sliceAdd[SLICE_W-1:0], accReg[PAD_W-1:SLICE_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
      carReg <= '0;
      accReg <= '0;
      lowReg <= '0;
      cyReg  <= 1'b0;
      outReg <= '0;
    end else if (ctl.load) begin
      sumReg <= PAD_W'(csaX);
      carReg <= PAD_W'({csaMaj[UP_W-2:0], 1'b0});
      lowReg <= sumWords[WORD_W-1:0];
      cyReg  <= 1'b0;
    end else if (ctl.step) begin
      sumReg <= sumReg >> SLICE_W;
      carReg <= carReg >> SLICE_W;
      cyReg  <= sliceAdd[SLICE_W];
      accReg <= accNext;
      if (ctl.last) outReg <= {accNext[UP_W-1:0], lowReg};
    end
  end

  assign result = outReg;

  // R8: the top slice never carries out of the result width
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |-> !sliceAdd[SLICE_W]);
  // R7: the result moves only when the final slice completes
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.last |=> $stable(result));
endmodule

// File: rtl/redundant_result_adder.sv
module redundant_result_adder
  import rra_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  parameter int SLICE_W   = 56
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [NUM_WORDS*WORD_W-1:0]       sumWords,
  input  logic [NUM_WORDS*(WORD_W+1)-1:0]   carryWords,
  output logic                              busy,
  output logic                              done,
  output logic [WORD_W*(NUM_WORDS+2)-1:0]   result
);
  localparam int UP_W       = WORD_W * (NUM_WORDS + 1);
  localparam int NUM_SLICES = (UP_W + SLICE_W - 1) / SLICE_W;

  rraCtl_t ctl;

  rra_ctrl #(.NUM_SLICES(NUM_SLICES)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  rra_datapath #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
    .SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .sumWords(sumWords), .carryWords(carryWords), .result(result)
  );
endmodule

// File: tb/test_redundant_result_adder.sv
module test_redundant_result_adder;
  localparam int K     = 16;
  localparam int N     = 8;
  localparam int SL    = 56;
  localparam int S_W   = N * K;
  localparam int C_W   = N * (K + 1);
  localparam int RES_W = K * (N + 2);
  localparam int NSL   = (K * (N + 1) + SL - 1) / SL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [S_W-1:0]   sumWords = '0;
  logic [C_W-1:0]   carryWords = '0;
  logic             busy, done;
  logic [RES_W-1:0] result;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  redundant_result_adder #(.WORD_W(K), .NUM_WORDS(N), .SLICE_W(SL)) i_redundant_result_adder (
    .clk(clk), .rstN(rstN), .start(start), .sumWords(sumWords),
    .carryWords(carryWords), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [RES_W-1:0] refSum(logic [S_W-1:0] s, logic [C_W-1:0] c);
    logic [RES_W-1:0] e = '0;
    for (int j = 0; j < N; j++) begin
      e += RES_W'(s[j*K +: K]) << (K * j);
      e += RES_W'(c[j*(K+1) +: K+1]) << (K * (j + 1));
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [RES_W-1:0] act, logic [RES_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randWords(output logic [S_W-1:0] s, output logic [C_W-1:0] c);
    for (int i = 0; i < S_W; i += 32) s[i +: 32] = $urandom;
    for (int i = 0; i < C_W; i += 8) c[i +: 8] = 8'($urandom);
  endtask

  // launch at negedge, wait for done, check latency, busy and result
  task automatic runOp(logic [S_W-1:0] s, logic [C_W-1:0] c, string req);
    int edges = 0;
    sumWords = s; carryWords = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5 busy after start", RES_W'(busy), RES_W'(1));
    while (!done && edges < 50) begin
      @(negedge clk);
      edges++;
    end
    check(edges == NSL, "R4 latency", RES_W'(edges), RES_W'(NSL));
    check(busy == 1'b0, "R5 busy low at done", RES_W'(busy), RES_W'(0));
    check(result == refSum(s, c), req, result, refSum(s, c));
    check(result[K-1:0] == s[K-1:0], "R3 low word", RES_W'(result[K-1:0]), RES_W'(s[K-1:0]));
  endtask

  initial begin
    logic [S_W-1:0]   s, s2;
    logic [C_W-1:0]   c, c2;
    logic [RES_W-1:0] held;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && result == '0, "R1 reset state", result, '0);
    rstN = 1'b1;
    @(negedge clk);

    runOp('0, '0, "R2 all zero");
    runOp('1, '1, "R8 all ones");
    s = '0; c = '0;
    for (int j = 0; j < N; j++) c[j*(K+1) + K] = 1'b1;
    runOp(s, c, "R2 top carry bits only");
    s = '0; c = '1;
    runOp(s, c, "R3 carries only");
    randWords(s, c); c = '0;
    runOp(s, c, "R2 sum words only");

    for (int t = 0; t < 40; t++) begin
      randWords(s, c);
      runOp(s, c, "R2 random");
    end

    // R6: start while busy is ignored
    randWords(s, c); randWords(s2, c2);
    sumWords = s; carryWords = c; start = 1'b1;
    @(negedge clk);
    sumWords = s2; carryWords = c2;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(result == refSum(s, c), "R6 start while busy", result, refSum(s, c));
    @(negedge clk);
    check(busy == 1'b0, "R6 no second run", RES_W'(busy), RES_W'(0));

    // R7 and R9: back-to-back start in the done cycle, result held meanwhile
    randWords(s, c);
    runOp(s, c, "R2 before back-to-back");
    held = result;
    randWords(s2, c2);
    sumWords = s2; carryWords = c2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 accepted in done cycle", RES_W'(busy), RES_W'(1));
    check(result == held, "R7 held while busy", result, held);
    while (!done) begin
      @(negedge clk);
      if (!done) check(result == held, "R7 held while busy", result, held);
    end
    check(result == refSum(s2, c2), "R9 back-to-back result", result, refSum(s2, c2));
    held = result;
    repeat (5) @(negedge clk);
    check(result == held, "R7 held while idle", result, held);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule